// File: doc/BRIEF.md
# Wait-Pin Interrupt Status Controller

This block gathers three interrupt sources for an external asynchronous memory controller and turns them into status bits and a CPU interrupt. The sources are a rising edge on the active-low wait pin, a line-trap strobe that flags an illegal access type or an invalid cache line size, and an extended-wait timeout. The timeout fires when the wait pin stays low during an extended access for more cycles than a programmed limit. The memory access state machine is outside this block. It supplies only a level that is high while an extended access is in progress, and the line-trap strobe.

Every source has a raw status bit and a masked status bit. The raw bit records each event. The masked bit records an event only while the enable for that source is on, and a masked bit that goes from 0 to 1 produces a one-cycle interrupt pulse. Software reaches the block through a small word-addressed port. Reads return data one cycle after the request. Status bits are cleared by writing 1.

Register map (word addresses): 0 = raw status, 1 = masked status, 2 = enable-set, 3 = enable-clear, 4 = maximum wait count.

Top module: `waitirq_ctrl`

## Requirements
- R1: Both status words place wait-rise at bit 2, line-trap at bit 1 and timeout at bit 0. Bits 31..3 of the status words and of the enable words always read 0, and writing 1 to those bits has no effect on any state.
- R2: A raw status bit is set by its event whether or not that source is enabled.
- R3: A masked status bit is set by its event only while the enable for that source is 1.
- R4: Writing 1 to a bit of the masked status word (address 1) clears that masked bit and the matching raw bit. Writing 0 leaves the bit unchanged.
- R5: Writing 1 to a bit of the raw status word (address 0) clears only that raw bit. Masked bits are unaffected.
- R6: The wait pin passes through a two-flop synchronizer. A 0-to-1 transition of `wait_n` raises the wait-rise event. A 1-to-0 transition raises no event.
- R7: While `ext_active` is high, the block counts the cycles in which the synchronized `wait_n` is low. The count stops while the pin is high and restarts at 0 when `ext_active` goes low. The timeout event fires once per access, when the count of low cycles exceeds the maximum wait count (address 4, reset 0).
- R8: A one-cycle pulse on `lt_strobe` raises the line-trap event.
- R9: `irq` is high for exactly one cycle each time one or more masked bits change from 0 to 1. It goes high in the first cycle in which the new bit can be read.
- R10: Writing 1 to a bit of address 2 sets that enable, and writing 1 to a bit of address 3 clears it. Both addresses read back the current 3-bit enable state.
- R11: When an event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R12: After reset, every status bit, every enable, the maximum wait count, `irq` and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_n | input | 1 | Asynchronous active-low wait pin |
| ext_active | input | 1 | High while an extended access is in progress |
| lt_strobe | input | 1 | Line-trap event strobe |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench sweeps all eight enable patterns and fires all three sources for each pattern. A design that gates the raw bits with the enables, or leaks disabled events into the masked word, produces the wrong raw or masked words, or the wrong number of interrupt cycles. Timeout runs cover a low time equal to the limit and one cycle longer, two short runs in separate accesses, and a low wait pin while no access is active. These runs catch an off-by-one compare, a counter that is not restarted between accesses, and a counter that runs outside an access. Further cases cover a falling edge on its own, a clear that lands in the same cycle as an event, and clears through each status word. These catch edge detection on the wrong polarity, a clear that wins over the event, and clears that reach the wrong word.

// File: rtl/wic_pkg.sv
package wic_pkg;
  localparam int NSRC = 3;
  localparam int SRC_TO = 0;
  localparam int SRC_LT = 1;
  localparam int SRC_WR = 2;
  localparam logic [2:0] A_RAW = 3'd0;
  localparam logic [2:0] A_MSK = 3'd1;
  localparam logic [2:0] A_ENS = 3'd2;
  localparam logic [2:0] A_ENC = 3'd3;
  localparam logic [2:0] A_MAX = 3'd4;
endpackage

// File: rtl/wic_sync.sv
module wic_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;

  // R6: an edge lasts one cycle
  p_rise_single_r6: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/wic_timeout.sv
module wic_timeout #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             waiting,
  input  logic [CNT_W-1:0] max_cnt,
  output logic             evt
);
  logic [CNT_W-1:0] cnt;
  logic             done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
      evt  <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (!active) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (waiting && !done) begin
        if (cnt == max_cnt) begin
          evt  <= 1'b1;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7: one timeout per access
  p_timeout_once_r7: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt);
  // R7: no timeout outside an access
  p_timeout_in_access_r7: assert property (@(posedge clk) disable iff (rst)
    evt |-> $past(active));
endmodule

// File: rtl/wic_status.sv
module wic_status
  import wic_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr_raw,
  input  logic [NSRC-1:0] clr_msk,
  input  logic [NSRC-1:0] en_set,
  input  logic [NSRC-1:0] en_clr,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] msk,
  output logic [NSRC-1:0] en,
  output logic            irq
);
  logic [NSRC-1:0] raw_d, msk_d, en_d;

  always_comb begin
    raw_d = (raw & ~(clr_raw | clr_msk)) | evt;
    msk_d = (msk & ~clr_msk) | (evt & en);
    en_d  = (en & ~en_clr) | en_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw <= '0;
      msk <= '0;
      en  <= '0;
      irq <= 1'b0;
    end else begin
      raw <= raw_d;
      msk <= msk_d;
      en  <= en_d;
      irq <= |(msk_d & ~msk);
    end
  end

  // R9: a pulse only when a masked bit newly rose
  p_irq_edge_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((msk & ~$past(msk)) != '0));

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    // R3: masked bit rises only when enabled
    p_mask_gate_r3: assert property (@(posedge clk) disable iff (rst)
      (msk[i] && !$past(msk[i])) |-> $past(en[i]));
    // R2: raw captures every event
    p_raw_record_r2: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> raw[i]);
    // R4: masked clear empties both words
    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
      (clr_msk[i] && !evt[i]) |=> (!msk[i] && !raw[i]));
    // R11: event beats clear
    p_setwins_r11: assert property (@(posedge clk) disable iff (rst)
      (evt[i] && en[i]) |=> msk[i]);
  end
endmodule

// File: rtl/waitirq_ctrl.sv
module waitirq_ctrl
  import wic_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wait_n,
  input  logic              ext_active,
  input  logic              lt_strobe,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int PAD_S = DATA_W - NSRC;
  localparam int PAD_C = DATA_W - CNT_W;

  logic            pin_lvl, pin_rise, to_evt;
  logic [CNT_W-1:0] max_q;
  logic [NSRC-1:0] evt, raw, msk, en;
  logic [NSRC-1:0] clr_raw, clr_msk, en_set, en_clr;
  logic [2:0]      a3;

  assign a3 = 3'(addr);

  wic_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .pin(wait_n), .level(pin_lvl), .rise(pin_rise)
  );

  wic_timeout #(.CNT_W(CNT_W)) u_to (
    .clk(clk), .rst(rst), .active(ext_active), .waiting(~pin_lvl),
    .max_cnt(max_q), .evt(to_evt)
  );

  always_comb begin
    evt         = '0;
    evt[SRC_TO] = to_evt;
    evt[SRC_LT] = lt_strobe;
    evt[SRC_WR] = pin_rise;
    clr_raw = (wr_en && a3 == A_RAW) ? wdata[NSRC-1:0] : '0;
    clr_msk = (wr_en && a3 == A_MSK) ? wdata[NSRC-1:0] : '0;
    en_set  = (wr_en && a3 == A_ENS) ? wdata[NSRC-1:0] : '0;
    en_clr  = (wr_en && a3 == A_ENC) ? wdata[NSRC-1:0] : '0;
  end

  wic_status u_stat (
    .clk(clk), .rst(rst), .evt(evt), .clr_raw(clr_raw), .clr_msk(clr_msk),
    .en_set(en_set), .en_clr(en_clr), .raw(raw), .msk(msk), .en(en), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      max_q <= '0;
    end else if (wr_en && a3 == A_MAX) begin
      max_q <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (a3)
        A_RAW:        rdata <= {{PAD_S{1'b0}}, raw};
        A_MSK:        rdata <= {{PAD_S{1'b0}}, msk};
        A_ENS, A_ENC: rdata <= {{PAD_S{1'b0}}, en};
        A_MAX:        rdata <= {{PAD_C{1'b0}}, max_q};
        default:      rdata <= '0;
      endcase
    end
  end

  // R1: upper status bits always read zero
  p_status_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && a3 <= A_ENC) |-> (rdata[DATA_W-1:NSRC] == '0));
endmodule

// File: tb/waitirq_ctrl_test.sv
`timescale 1ns/1ps
module waitirq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wait_n = 1'b1, ext_active = 1'b0, lt_strobe = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0, irq_cnt = 0;
  logic [31:0] v;

  waitirq_ctrl uut (
    .clk(clk), .rst(rst), .wait_n(wait_n), .ext_active(ext_active),
    .lt_strobe(lt_strobe), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) if (irq) irq_cnt++;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lt_pulse();
    @(negedge clk); lt_strobe = 1'b1;
    @(negedge clk); lt_strobe = 1'b0;
    idle(2);
  endtask

  // one access with wait_n low for n cycles, then released
  task automatic access(input int n);
    @(negedge clk); ext_active = 1'b1; wait_n = 1'b0;
    idle(n); wait_n = 1'b1;
    idle(6); ext_active = 1'b0;
    idle(3);
  endtask

  task automatic clear_all();
    wr(3'd1, 32'h7); wr(3'd0, 32'h7);
  endtask

  initial begin
    idle(3); rst = 1'b0; idle(1);
    // R12: reset state
    chk("R12 irq", {31'b0, irq}, 0);
    chk("R12 rdata", rdata, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk("R12 reg", v, 0);
    end

    // R1 / R10: upper-bit writes ignored, enables set/clear
    wr(3'd2, 32'hFFFF_FFF8); rd(3'd2, v); chk("R1 enset upper", v, 0);
    wr(3'd2, 32'h5); rd(3'd3, v); chk("R10 enable set", v, 5);
    wr(3'd3, 32'h4); rd(3'd2, v); chk("R10 enable clear", v, 1);
    wr(3'd3, 32'h7);

    // Sweep of every enable pattern: R2 R3 R6 R7 R8 R9 R1
    wr(3'd4, 32'd1);
    for (int e = 0; e < 8; e++) begin
      wr(3'd3, 32'h7); wr(3'd2, 32'(e)); clear_all();
      irq_cnt = 0;
      lt_pulse();
      access(4);
      rd(3'd0, v); chk("R2 raw all sources", v, 32'h7);
      rd(3'd1, v); chk("R3 masked follows enable", v, 32'(e));
      chk("R9 irq cycles", irq_cnt, $countones(e[2:0]));
    end

    // R6: falling edge alone raises nothing, then rise sets bit 2
    wr(3'd3, 32'h7); wr(3'd2, 32'h7); clear_all();
    @(negedge clk); wait_n = 1'b0; idle(6);
    rd(3'd0, v); chk("R6 fall no event", v, 0);
    wait_n = 1'b1; idle(5);
    rd(3'd0, v); chk("R6 rise sets bit2", v, 32'h4);
    clear_all();

    // R7: boundary at the limit
    wr(3'd4, 32'd3); clear_all();
    access(3); rd(3'd0, v); chk("R7 low == max no timeout", v & 32'h1, 0);
    clear_all();
    access(4); rd(3'd0, v); chk("R7 low > max timeout", v & 32'h1, 1);
    clear_all();
    access(2); access(2); rd(3'd0, v); chk("R7 restart per access", v & 32'h1, 0);
    clear_all();
    // low pin with no access active
    @(negedge clk); wait_n = 1'b0; idle(10); wait_n = 1'b1; idle(5);
    rd(3'd0, v); chk("R7 idle no timeout", v & 32'h1, 0);
    clear_all();
    // R8: line trap only
    lt_pulse(); rd(3'd1, v); chk("R8 line trap bit1", v, 32'h2);

    // R4: masked clear empties raw too, write of 0 is no-op
    wr(3'd1, 32'h0); rd(3'd1, v); chk("R4 zero write keeps", v, 32'h2);
    wr(3'd1, 32'hFFFF_FFFA); rd(3'd1, v); chk("R4 masked cleared", v, 0);
    rd(3'd0, v); chk("R4 raw cleared", v, 0);

    // R5: raw clear leaves masked
    lt_pulse(); wr(3'd0, 32'h2);
    rd(3'd0, v); chk("R5 raw cleared", v, 0);
    rd(3'd1, v); chk("R5 masked kept", v, 32'h2);
    clear_all();

    // R11: event and clear in the same cycle
    @(negedge clk); wr_en = 1'b1; addr = 3'd1; wdata = 32'h2; lt_strobe = 1'b1;
    @(negedge clk); wr_en = 1'b0; lt_strobe = 1'b0;
    rd(3'd1, v); chk("R11 set wins masked", v, 32'h2);
    rd(3'd0, v); chk("R11 set wins raw", v, 32'h2);
    rd(3'd1, v); chk("R1 masked upper zero", v & 32'hFFFF_FFF8, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog got=1 exp=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule